// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block turns a two-dimensional vector through an arbitrary angle without a multiplier. A signed X/Y pair and an unsigned phase word enter together on one cycle. The block first turns the vector by a whole number of right angles, by swapping and negating its parts. A chain of registered shift-and-add stages then removes what is left of the angle. One new vector can enter on every enabled cycle. Results leave in the order the vectors entered.

The phase word covers a full turn: 2^ZW units make 360 degrees. X and Y are widened by two guard bits on entry. The outputs therefore carry the uncompensated CORDIC gain of about 1.6468 without wrapping. The unused part of the angle is also given out, as a small signed residual. The clock enable stalls the whole pipeline at once. Latency is counted in enabled cycles only.

Top module: `cordic_rotator`

## Requirements
- R1: A low `rst_n` at a rising edge clears the X, Y and Z registers of every stage, whatever `en` is. After that edge `xo`, `yo` and `zo` read zero. No stale value from before the reset reaches the outputs afterwards.
- R2: While `en` is low, no register changes and the inputs are ignored. `xo`, `yo` and `zo` stay stable, and cycles with `en` low do not count toward latency.
- R3: A vector sampled at an enabled rising edge appears on the outputs after the 13th enabled rising edge, counting the one that sampled it. Until then the outputs still show earlier work. One vector is accepted per enabled edge, and results come out in input order.
- R4: Bits `zi[15:14]` choose the coarse turn. 00 keeps (X, Y), 01 gives (-Y, X), 10 gives (-X, -Y) and 11 gives (Y, -X). With `zi[13:0]` = 0, `xo` and `yo` are within 16 LSB of 1.64676 times that mapped pair.
- R5: Let θ = 2π·(zi − zo)/65536, with `zo` read as signed. Then `xo` is within 8 LSB of 1.64676·(x·cosθ − y·sinθ), and `yo` is within 8 LSB of 1.64676·(x·sinθ + y·cosθ).
- R6: `zo` is the residual angle, sign-extended from the 15-bit internal angle. Read as signed, it always lies between -6 and +6.
- R7: `xo` and `yo` are 18-bit two's complement. Full-scale inputs, -32768 included, give results that obey R5 with no wraparound, and |xo| and |yo| never exceed 81920.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Pipeline advance enable |
| xi | input | 16 | Input X, signed |
| yi | input | 16 | Input Y, signed |
| zi | input | 16 | Rotation phase, unsigned, full turn = 65536 |
| xo | output | 18 | Rotated X with gain, signed |
| yo | output | 18 | Rotated Y with gain, signed |
| zo | output | 16 | Residual angle, signed |

## Verification
The bound checker watches four things on every cycle:
- the outputs read zero after any reset edge;
- the outputs do not move across a disabled edge;
- the residual angle stays within its convergence bound;
- the outputs stay within the headroom that the gain allows.

Three things can only be shown by the bench's scenarios: the numeric accuracy of the rotation, the quadrant mapping, and the exact count of 13 enabled edges. The same holds for in-order streaming and for a reset in mid-stream flushing every stage. The bench compares each result against a floating-point rotation, run from the input and the reported residual.

// File: rtl/cordic_rot_pkg.sv
`timescale 1ns/1ps
// Package: cordic_rot_pkg
// Shared definitions for the CORDIC rotator: the coarse quadrant code and
// the per-stage arctangent constants. Assumes angles are binary fractions of
// a full turn; the base table is for a 16-bit phase word and is rescaled by
// a power of two for other phase widths.
package cordic_rot_pkg;

    // Coarse turn selected by the two phase MSBs; order is behaviour.
    typedef enum logic [1:0] {
        QUAD_0   = 2'b00,
        QUAD_90  = 2'b01,
        QUAD_180 = 2'b10,
        QUAD_270 = 2'b11
    } quad_e;

    // atan(2^-idx) in units of 2^-16 turn, rounded; rescaled to zw bits.
    function automatic int stage_angle(input int idx, input int zw);
        int base;
        case (idx)
            0:       base = 8192;
            1:       base = 4836;
            2:       base = 2555;
            3:       base = 1297;
            4:       base = 651;
            5:       base = 326;
            6:       base = 163;
            7:       base = 81;
            8:       base = 41;
            9:       base = 20;
            10:      base = 10;
            11:      base = 5;
            default: base = (idx < 30) ? (10430 >> idx) : 0;
        endcase
        if (zw >= 16) begin
            return base << (zw - 16);
        end
        return base >> (16 - zw);
    endfunction

endpackage

// File: rtl/cordic_quadrant.sv
`timescale 1ns/1ps
// Module: cordic_quadrant
// Entry stage of the rotator. Sign-extends X and Y by two guard bits, turns
// the vector by 0/90/180/270 degrees from the two phase MSBs, and registers
// the result with the remaining phase bits as a non-negative residual angle.
// Assumes ZW >= 4; the residual is ZW-1 bits wide, so its MSB starts at zero.
module cordic_quadrant #(
    parameter int DW = 16,
    parameter int ZW = 16,
    localparam int IW = DW + 2,
    localparam int RW = ZW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DW-1:0]        xi,
    input  logic [DW-1:0]        yi,
    input  logic [ZW-1:0]        zi,
    output logic signed [IW-1:0] x_q,
    output logic signed [IW-1:0] y_q,
    output logic signed [RW-1:0] z_q
);
    import cordic_rot_pkg::*;

    logic signed [IW-1:0] x_ext;
    logic signed [IW-1:0] y_ext;
    logic signed [IW-1:0] x_map;
    logic signed [IW-1:0] y_map;
    logic signed [RW-1:0] z_res;
    quad_e                quad;

    // Widen the inputs and select the coarse turn.
    always_comb begin
        x_ext = {{2{xi[DW-1]}}, xi};
        y_ext = {{2{yi[DW-1]}}, yi};
        quad  = quad_e'(zi[ZW-1 -: 2]);
        z_res = {2'b00, zi[ZW-3:0]};
        case (quad)
            QUAD_90: begin
                x_map = -y_ext;
                y_map = x_ext;
            end
            QUAD_180: begin
                x_map = -x_ext;
                y_map = -y_ext;
            end
            QUAD_270: begin
                x_map = y_ext;
                y_map = -x_ext;
            end
            default: begin
                x_map = x_ext;
                y_map = y_ext;
            end
        endcase
    end

    // Entry register: cleared by reset, loaded only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (en) begin
            x_q <= x_map;
            y_q <= y_map;
            z_q <= z_res;
        end
    end

endmodule

// File: rtl/cordic_microstage.sv
`timescale 1ns/1ps
// Module: cordic_microstage
// One registered micro-rotation. The sign of the residual angle picks the
// direction. X and Y are updated with each other shifted arithmetically right
// by SHIFT, and the stage angle ANGLE is taken from or added to the residual.
// Assumes ANGLE fits in RW-1 bits and that SHIFT < IW.
module cordic_microstage #(
    parameter int IW    = 18,
    parameter int RW    = 15,
    parameter int SHIFT = 0,
    parameter int ANGLE = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [RW-1:0] z_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [RW-1:0] z_o
);
    localparam logic signed [RW-1:0] STEP = RW'(ANGLE);

    logic signed [IW-1:0] x_sh;
    logic signed [IW-1:0] y_sh;
    logic signed [IW-1:0] x_nx;
    logic signed [IW-1:0] y_nx;
    logic signed [RW-1:0] z_nx;
    logic                 z_neg;

    // Shift-and-add step, direction from the residual sign.
    always_comb begin
        x_sh  = x_i >>> SHIFT;
        y_sh  = y_i >>> SHIFT;
        z_neg = z_i[RW-1];
        if (!z_neg) begin
            x_nx = x_i - y_sh;
            y_nx = y_i + x_sh;
            z_nx = z_i - STEP;
        end else begin
            x_nx = x_i + y_sh;
            y_nx = y_i - x_sh;
            z_nx = z_i + STEP;
        end
    end

    // Stage register: cleared by reset, loaded only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else if (en) begin
            x_o <= x_nx;
            y_o <= y_nx;
            z_o <= z_nx;
        end
    end

endmodule

// File: rtl/cordic_rotator.sv
`timescale 1ns/1ps
// Module: cordic_rotator
// Top of the pipelined CORDIC rotator. It holds one quadrant entry stage
// followed by STAGES micro-rotation stages, where stage g shifts by g. The
// outputs come straight from the last stage's registers. The gain is left
// uncompensated. Assumes ZW >= 4 and STAGES < IW.
module cordic_rotator #(
    parameter int DW     = 16,
    parameter int ZW     = 16,
    parameter int STAGES = 12,
    localparam int IW = DW + 2,
    localparam int RW = ZW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] xi,
    input  logic [DW-1:0] yi,
    input  logic [ZW-1:0] zi,
    output logic [IW-1:0] xo,
    output logic [IW-1:0] yo,
    output logic [ZW-1:0] zo
);
    logic signed [IW-1:0] x_pipe [STAGES+1];
    logic signed [IW-1:0] y_pipe [STAGES+1];
    logic signed [RW-1:0] z_pipe [STAGES+1];

    cordic_quadrant #(
        .DW(DW),
        .ZW(ZW)
    ) u_quad (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .xi   (xi),
        .yi   (yi),
        .zi   (zi),
        .x_q  (x_pipe[0]),
        .y_q  (y_pipe[0]),
        .z_q  (z_pipe[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        cordic_microstage #(
            .IW   (IW),
            .RW   (RW),
            .SHIFT(g),
            .ANGLE(cordic_rot_pkg::stage_angle(g, ZW))
        ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en),
            .x_i  (x_pipe[g]),
            .y_i  (y_pipe[g]),
            .z_i  (z_pipe[g]),
            .x_o  (x_pipe[g+1]),
            .y_o  (y_pipe[g+1]),
            .z_o  (z_pipe[g+1])
        );
    end

    // Drive the ports from the final stage; residual sign-extended by one bit.
    always_comb begin
        xo = x_pipe[STAGES];
        yo = y_pipe[STAGES];
        zo = {z_pipe[STAGES][RW-1], z_pipe[STAGES]};
    end

endmodule

// File: rtl/cordic_rotator_chk.sv
`timescale 1ns/1ps
// Module: cordic_rotator_chk
// Cycle-by-cycle checks on the rotator's ports, bound into every instance.
// Assumes the default of 12 stages when it bounds the residual.
module cordic_rotator_chk #(
    parameter int DW = 16,
    parameter int ZW = 16,
    localparam int IW = DW + 2,
    localparam int OUT_LIM = (2 ** (DW - 1)) * 5 / 2,
    localparam int RES_LIM = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [IW-1:0] xo,
    input logic [IW-1:0] yo,
    input logic [ZW-1:0] zo
);
    logic rst_q;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // Outputs seen now were written at the previous edge.
    always_ff @(posedge clk) begin
        if (rst_q == 1'b0) begin
            // R1
            reset_clear_chk: assert (xo == '0 && yo == '0 && zo == '0)
                else $error("outputs not cleared by reset");
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(xo) && $stable(yo) && $stable(zo)));

    // R6
    residual_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(zo) <= RES_LIM) && ($signed(zo) >= -RES_LIM));

    // R7
    output_headroom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(xo) <= OUT_LIM) && ($signed(xo) >= -OUT_LIM) &&
        ($signed(yo) <= OUT_LIM) && ($signed(yo) >= -OUT_LIM));

endmodule

bind cordic_rotator cordic_rotator_chk #(
    .DW(DW),
    .ZW(ZW)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .xo   (xo),
    .yo   (yo),
    .zo   (zo)
);

// File: tb/sim_cordic_rotator.sv
`timescale 1ns/1ps
module sim_cordic_rotator;
    localparam int  DW  = 16;
    localparam int  ZW  = 16;
    localparam int  IW  = DW + 2;
    localparam int  NV  = 12;
    localparam int  LAT = 12;
    localparam int  TOL = 8;
    localparam real KG  = 1.646760258;
    localparam real PI  = 3.14159265358979;

    // {x, y, z}
    localparam logic [47:0] VEC [NV] = '{
        {16'h2710, 16'h0000, 16'h0000},
        {16'h2710, 16'h0000, 16'h4000},
        {16'h2710, 16'h0000, 16'h8000},
        {16'h2710, 16'h0000, 16'hC000},
        {16'h2EE0, 16'hEC78, 16'h1555},
        {16'hB1E0, 16'h1B58, 16'h2AAA},
        {16'h7FFF, 16'h7FFF, 16'h6000},
        {16'h8000, 16'h8000, 16'hA123},
        {16'h8000, 16'h7FFF, 16'hFFFF},
        {16'h0001, 16'hFFFF, 16'h3FFF},
        {16'h0000, 16'h0000, 16'h1234},
        {16'h61A8, 16'h8AD0, 16'h8001}
    };

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          en    = 1'b0;
    logic [DW-1:0] xi    = '0;
    logic [DW-1:0] yi    = '0;
    logic [ZW-1:0] zi    = '0;
    logic [IW-1:0] xo;
    logic [IW-1:0] yo;
    logic [ZW-1:0] zo;
    int checks = 0;
    int fails  = 0;

    cordic_rotator #(.DW(DW), .ZW(ZW), .STAGES(12)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .xi(xi), .yi(yi), .zi(zi),
        .xo(xo), .yo(yo), .zo(zo)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [47:0] v);
        xi = v[47:32];
        yi = v[31:16];
        zi = v[15:0];
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare the outputs against a scaled float rotation of vector v.
    task automatic check_model(input logic [47:0] v);
        int  x, y, zr, mx, my;
        real th, ex, ey;
        x  = int'($signed(v[47:32]));
        y  = int'($signed(v[31:16]));
        zr = int'($signed(zo));
        th = 2.0 * PI * real'(int'(v[15:0]) - zr) / 65536.0;
        ex = KG * (real'(x) * $cos(th) - real'(y) * $sin(th));
        ey = KG * (real'(x) * $sin(th) + real'(y) * $cos(th));
        check("R5 x", int'($signed(xo)), int'(ex), TOL);
        check("R5 y", int'($signed(yo)), int'(ey), TOL);
        check("R6 residual", zr, 0, 6);
        check("R7 headroom x", int'($signed(xo)), 0, 81920);
        if (v[13:0] == 14'd0) begin
            case (v[15:14])
                2'b00:   begin mx = x;  my = y;  end
                2'b01:   begin mx = -y; my = x;  end
                2'b10:   begin mx = -x; my = -y; end
                default: begin mx = y;  my = -x; end
            endcase
            check("R4 quadrant x", int'($signed(xo)), int'(KG * real'(mx)), 16);
            check("R4 quadrant y", int'($signed(yo)), int'(KG * real'(my)), 16);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [IW-1:0] hx, hy;
        logic [ZW-1:0] hz;
        repeat (3) tick();
        // R1: state after reset
        check("R1 reset xo", int'($signed(xo)), 0, 0);
        check("R1 reset yo", int'($signed(yo)), 0, 0);
        check("R1 reset zo", int'($signed(zo)), 0, 0);
        rst_n = 1'b1;
        en    = 1'b1;

        // R3/R5: table streamed back to back, results checked in order
        for (int c = 0; c < NV + LAT; c++) begin
            if (c < NV) drive(VEC[c]);
            else        drive('0);
            tick();
            if (c >= LAT) check_model(VEC[c - LAT]);
        end

        // R3: exact latency of 13 enabled edges
        drive(VEC[0]);
        tick();
        drive('0);
        repeat (LAT - 1) tick();
        check("R3 not yet out", int'($signed(xo)), 0, 0);
        tick();
        check_model(VEC[0]);

        // R2: disabled edges hold state, ignore inputs and do not count
        drive(VEC[5]);
        tick();
        en = 1'b0;
        drive(VEC[6]);
        hx = xo; hy = yo; hz = zo;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R2 hold xo", int'($signed(xo)), int'($signed(hx)), 0);
            check("R2 hold yo", int'($signed(yo)), int'($signed(hy)), 0);
            check("R2 hold zo", int'($signed(zo)), int'($signed(hz)), 0);
        end
        en = 1'b1;
        drive('0);
        repeat (LAT - 1) tick();
        check("R2 stall not counted", int'($signed(yo)), 0, 0);
        tick();
        check_model(VEC[5]);

        // R1: reset mid-stream overrides a low enable and flushes all stages
        for (int k = 4; k < 10; k++) begin
            drive(VEC[k]);
            tick();
        end
        rst_n = 1'b0;
        en    = 1'b0;
        tick();
        check("R1 mid reset xo", int'($signed(xo)), 0, 0);
        check("R1 mid reset zo", int'($signed(zo)), 0, 0);
        rst_n = 1'b1;
        en    = 1'b1;
        drive('0);
        for (int k = 0; k < LAT; k++) begin
            tick();
            check("R1 flushed xo", int'($signed(xo)), 0, 0);
            check("R1 flushed yo", int'($signed(yo)), 0, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule